// File: doc/BRIEF.md
# Wrapping Burst Address Sequencer

This block produces the array address for each beat of a four-beat burst in a synchronous memory core. A load cycle with the device selected captures an external start address. Each later advance cycle steps the two low address bits to the next beat. The upper bits stay fixed, so a burst never leaves its aligned group of four words. A static order input selects between two orders. Linear order counts upward from the start and wraps inside the group. Interleaved order XORs the start's low bits with a running beat count.

The memory core drives the block once per clock. It has no data stream, so every pin is a plain control or status signal with no handshake. An active-low clock enable freezes the block completely. A load cycle issued while the device is deselected ends any burst in progress. The address output is held at its last value, and later advance cycles leave it unchanged until the next selected load.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it rises until the first command, `burst_act` is 0 and `arr_addr` is all zeros.
- R2: A rising edge with `cke_n`=0, `advance`=0 and `chip_sel`=1 loads `addr_in`. From the next cycle `arr_addr` equals that value and `burst_act` is 1, in either order mode.
- R3: On an edge with `advance`=1, `addr_in` has no effect, and `arr_addr` bits above bit 1 keep their value.
- R4: With `order_xor`=0 (linear), beat n of a burst (n counted from 0 at the load) has `arr_addr[1:0]` = (start[1:0] + n) mod 4.
- R5: With `order_xor`=1 (interleaved), beat n has `arr_addr[1:0]` = start[1:0] XOR (n mod 4).
- R6: Advance cycles after the fourth beat keep cycling through the same four addresses with a period of four. There is no carry into bit 2.
- R7: A rising edge with `cke_n`=0, `advance`=0 and `chip_sel`=0 clears `burst_act` and leaves `arr_addr` unchanged.
- R8: A rising edge with `cke_n`=1 changes neither `arr_addr` nor `burst_act`, whatever the other inputs are.
- R9: An advance cycle with no burst active (`burst_act`=0) leaves `arr_addr` unchanged and `burst_act` at 0.
- R10: A selected load in the middle of a burst restarts the sequence at the new start address with beat count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Active-low clock enable; 1 freezes all state |
| advance | input | 1 | 1 = step the burst, 0 = load/terminate command |
| chip_sel | input | 1 | 1 = device selected for a load command |
| order_xor | input | 1 | 1 = interleaved order, 0 = linear order (static) |
| addr_in | input | AW (17) | External start address |
| arr_addr | output | AW (17) | Array address of the current beat |
| burst_act | output | 1 | A burst is in progress |

## Verification
Bursts are started from each of the four low-bit start values in both orders and run past the fourth beat. Linear wrapping, XOR ordering and the absence of carry into the upper bits are therefore each observed on their own. Advance cycles carry changing junk on `addr_in`, which shows whether the external address leaks in. Frozen cycles carry load commands, which separates a working clock enable from one that only blocks stepping. A deselected load followed by advances shows that termination stops both the flag and the stepping, and a mid-burst reload shows that the beat count is reset.

// File: rtl/burst_pkg.sv
package burst_pkg;

  // Command seen at one clock edge, after the enable and selection decode
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,   // nothing changes
    CMD_LOAD = 2'd1,   // capture a new start address
    CMD_STOP = 2'd2,   // terminate the burst in progress
    CMD_STEP = 2'd3    // move to the next beat
  } burst_cmd_e;

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_pkg::*;
(
  input  logic       cke_n,
  input  logic       advance,
  input  logic       chip_sel,
  input  logic       active,
  output burst_cmd_e cmd
);

  always_comb begin
    if (cke_n) begin
      cmd = CMD_HOLD;
    end else if (!advance) begin
      cmd = chip_sel ? CMD_LOAD : CMD_STOP;
    end else begin
      cmd = active ? CMD_STEP : CMD_HOLD;
    end
  end

endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_pkg::*;
#(
  parameter int AW = 17,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  burst_cmd_e    cmd,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] base,
  output logic [BB-1:0] beat,
  output logic          active
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base   <= '0;
      beat   <= '0;
      active <= 1'b0;
    end else begin
      case (cmd)
        CMD_LOAD: begin
          base   <= addr_in;
          beat   <= '0;
          active <= 1'b1;
        end
        CMD_STOP: active <= 1'b0;
        CMD_STEP: beat   <= beat + BB'(1);
        default: ;
      endcase
    end
  end

  // Termination clears the flag but keeps the captured start
  assert_stop_keeps_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_STOP) |=> (!active && $stable(base)));

  // A load always starts at beat 0
  assert_load_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LOAD) |=> (beat == '0));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map #(
  parameter int AW = 17,
  parameter int BB = 2
) (
  input  logic [AW-1:0] base,
  input  logic [BB-1:0] beat,
  input  logic          order_xor,
  output logic [AW-1:0] addr
);

  logic [BB-1:0] low_lin;
  logic [BB-1:0] low_xor;
  logic [BB-1:0] low_sel;

  always_comb begin
    low_lin = base[BB-1:0] + beat;
    low_xor = base[BB-1:0] ^ beat;
    low_sel = order_xor ? low_xor : low_lin;
  end

  generate
    if (AW > BB) begin : g_upper
      assign addr = {base[AW-1:BB], low_sel};
    end else begin : g_narrow
      assign addr = low_sel;
    end
  endgenerate

  always_comb begin
    assert_beat0_is_start_R2: assert (beat != '0 || addr == base);
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int AW = 17,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cke_n,
  input  logic          advance,
  input  logic          chip_sel,
  input  logic          order_xor,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] arr_addr,
  output logic          burst_act
);

  burst_cmd_e    cmd;
  logic [AW-1:0] base;
  logic [BB-1:0] beat;

  burst_cmd_decode u_dec (
    .cke_n    (cke_n),
    .advance  (advance),
    .chip_sel (chip_sel),
    .active   (burst_act),
    .cmd      (cmd)
  );

  burst_seq_ctrl #(.AW(AW), .BB(BB)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .addr_in (addr_in),
    .base    (base),
    .beat    (beat),
    .active  (burst_act)
  );

  burst_order_map #(.AW(AW), .BB(BB)) u_map (
    .base      (base),
    .beat      (beat),
    .order_xor (order_xor),
    .addr      (arr_addr)
  );

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !advance && chip_sel) |=> (burst_act && arr_addr == $past(addr_in)));

  assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && advance) |=> (arr_addr[AW-1:BB] == $past(arr_addr[AW-1:BB])));

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && advance && burst_act && !order_xor) |=>
      (arr_addr[BB-1:0] == $past(arr_addr[BB-1:0]) + BB'(1)));

  assert_terminate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && !advance && !chip_sel) |=> !burst_act);

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cke_n |=> ($stable(arr_addr) && $stable(burst_act)));

  assert_idle_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_n && advance && !burst_act) |=> ($stable(arr_addr) && !burst_act));

endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 17;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cke_n = 1'b0;
  logic          advance = 1'b1;
  logic          chip_sel = 1'b0;
  logic          order_xor = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] arr_addr;
  logic          burst_act;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // Scoreboard queues: expected {act, addr} and the requirement tag
  logic [AW:0] q_exp[$];
  string       q_req[$];

  // Bench reference state, built from the requirement text
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_act = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.AW(AW), .BB(2)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .advance(advance),
    .chip_sel(chip_sel), .order_xor(order_xor), .addr_in(addr_in),
    .arr_addr(arr_addr), .burst_act(burst_act)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] lo;
    lo = order_xor ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic check(input string req, input logic [AW:0] got, input logic [AW:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s act/addr got %0b/%h expected %0b/%h",
               req, got[AW], got[AW-1:0], exp[AW], exp[AW-1:0]);
    end
  endtask

  // Driver: one clock of stimulus, expected result pushed for the monitor
  task automatic drive(input logic frz, input logic adv, input logic sel,
                       input logic [AW-1:0] a, input string req);
    @(negedge clk);
    cke_n = frz; advance = adv; chip_sel = sel; addr_in = a;
    if (!frz) begin
      if (!adv) begin
        if (sel) begin m_base = a; m_beat = 2'd0; m_act = 1'b1; end
        else m_act = 1'b0;
      end else if (m_act) begin
        m_beat = m_beat + 2'd1;
      end
    end
    q_exp.push_back({m_act, model_addr()});
    q_req.push_back(req);
  endtask

  // Monitor: samples a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (q_exp.size() > 0) begin
        logic [AW:0] e;
        string r;
        e = q_exp.pop_front();
        r = q_req.pop_front();
        check(r, {burst_act, arr_addr}, e);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check("R1", {burst_act, arr_addr}, '0);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b0, 1'b1, 1'b0, 17'h1ABCD, "R1_R9");

    // R2 R4: linear burst from low bits 2, run past the fourth beat (R6), junk on addr_in (R3)
    order_xor = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 17'h12346, "R2");
    for (int i = 0; i < 6; i++) drive(1'b0, 1'b1, 1'b1, 17'h0F0F0 ^ AW'(i * 977), "R4_R3_R6");

    // R8: frozen cycles carrying load and terminate commands
    drive(1'b1, 1'b0, 1'b1, 17'h00777, "R8");
    drive(1'b1, 1'b0, 1'b0, 17'h00000, "R8");
    drive(1'b1, 1'b1, 1'b1, 17'h1FFFF, "R8");

    // R10: reload in mid burst
    drive(1'b0, 1'b1, 1'b0, 17'h00001, "R4");
    drive(1'b0, 1'b0, 1'b1, 17'h0ABC1, "R10");
    drive(1'b0, 1'b1, 1'b0, 17'h15555, "R10_R4");

    // R7 then R9: terminate, then advances do nothing
    drive(1'b0, 1'b0, 1'b0, 17'h13333, "R7");
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b1, 17'h02222, "R9");

    // All starts, both orders, eight beats each (R4 R5 R6)
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        @(negedge clk); order_xor = m[0];
        drive(1'b0, 1'b0, 1'b1, {15'h5A5A ^ 15'(s * 301), 2'(s)}, "R2");
        for (int k = 0; k < 8; k++)
          drive(1'b0, 1'b1, 1'b0, AW'(k * 4093), m[0] ? "R5_R6" : "R4_R6");
      end
    end

    // Interleaved: freeze mid burst, then terminate and idle advance
    drive(1'b0, 1'b0, 1'b1, 17'h1FFFF, "R2");
    drive(1'b0, 1'b1, 1'b1, 17'h00000, "R5");
    drive(1'b1, 1'b1, 1'b1, 17'h00000, "R8");
    drive(1'b0, 1'b1, 1'b1, 17'h00000, "R5");
    drive(1'b0, 1'b0, 1'b0, 17'h00004, "R7");
    drive(1'b0, 1'b1, 1'b0, 17'h00008, "R9");

    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    finish_run();
  end

endmodule